// File: doc/BRIEF.md
# Software-Triggerable Event Generator

This peripheral holds a small set of trigger channels. Each channel keeps one sticky event flag, and two sources can fire it: a CPU write to the channel's task register, or a one-cycle pulse from a hardware event-routing fabric. Both sources have the same effect. Whenever a flag goes from clear to set, the unit sends a one-cycle pulse out on that channel's event output, so other blocks can chain from it.

Interrupt enabling is handled apart from event generation. A per-channel enable mask is changed only through a set register and a clear register. The single level interrupt request is high while at least one channel has both its flag and its enable bit set. Software uses the unit as a deferred-work doorbell. A time-critical handler, or a routed hardware event, fires a task. A lower-priority handler then reads the flag, clears it by writing 0, and does the work.

Top module: `trig_evt_unit`

## Requirements
- R1: A bus write with wdata bit 0 = 1 to task register n (byte offset 0x000 + 4·n) sets flag n. The flag shows as bit 0 of event register n (offset 0x100 + 4·n) and is visible in the cycle after the write edge.
- R2: A one-cycle pulse on hw_task[n] sets flag n with exactly the same timing and effect as an R1 write.
- R3: A set flag stays set until a bus write with wdata bit 0 = 0 reaches event register n. A write with bit 0 = 1 to an event register changes nothing.
- R4: A write to the enable-set register (offset 0x304) sets every mask bit whose wdata bit is 1. Bits written as 0 are left unchanged.
- R5: A write to the enable-clear register (offset 0x308) clears every mask bit whose wdata bit is 1. Bits written as 0 are left unchanged. Reading offset 0x300, 0x304 or 0x308 returns the mask in bits NUM_CH-1:0. Writes to 0x300 are ignored.
- R6: A flag sets even when its enable bit is 0. Setting an enable bit never sets a flag and never produces an event pulse.
- R7: irq is high exactly while some channel has both its flag and its enable bit set. It rises in the cycle the flag becomes visible, or the cycle after the enabling write. It falls in the cycle after the write that clears the last such flag or enable bit.
- R8: If a task (software or hardware) and a clear hit the same channel on the same edge, the flag ends up set.
- R9: evt_pulse[n] is high for exactly one cycle each time flag n rises. It stays low when a task fires on a flag that is already set.
- R10: Task registers read as 0. A write with wdata bit 0 = 0 to a task register has no effect.
- R11: After reset, all flags are 0, the mask is 0, and irq, evt_pulse and bus_rdata are all 0.
- R12: bus_rdata takes the selected value, as it stood before the edge, on the edge where bus_rd is sampled high. It holds that value until the next read. Unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_task | input | NUM_CH | Task pulses from the routing fabric |
| evt_pulse | output | NUM_CH | One-cycle pulse when a flag rises |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach is a clear and a task meeting on the same channel on the same edge. The bus carries only one write per cycle, so the clear must come over the bus while the task comes from hw_task in that same cycle. The stimulus builds this collision both with the flag already set and with it clear, so that both the surviving flag and the presence or absence of a pulse are checked. A reference model in the bench tracks every flag and the mask. It predicts pulse, irq and read data for every cycle, including reads that land on the same edge as a change.

// File: rtl/trig_evt_pkg.sv
package trig_evt_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned WORD_W = 6;

    localparam logic [3:0] REGION_TASK = 4'h0;
    localparam logic [3:0] REGION_EVT  = 4'h1;

    localparam logic [ADDR_W-1:0] OFS_MASK_RD  = 12'h300;
    localparam logic [ADDR_W-1:0] OFS_MASK_SET = 12'h304;
    localparam logic [ADDR_W-1:0] OFS_MASK_CLR = 12'h308;

endpackage

// File: rtl/trig_evt_decode.sv
module trig_evt_decode
    import trig_evt_pkg::*;
#(
    parameter int unsigned NUM_CH = 16
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NUM_CH-1:0] flags,
    input  logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] sw_trig,
    output logic [NUM_CH-1:0] sw_clr,
    output logic [NUM_CH-1:0] en_set,
    output logic [NUM_CH-1:0] en_clr,
    output logic [DATA_W-1:0] rd_value
);

    logic [WORD_W-1:0] word;
    logic [NUM_CH-1:0] hit;
    logic              aligned;
    logic              in_task;
    logic              in_evt;
    logic              unused_hi;

    assign word      = addr[WORD_W+1:2];
    assign aligned   = (addr[1:0] == 2'b00) && (int'(word) < NUM_CH);
    assign in_task   = aligned && (addr[ADDR_W-1:8] == REGION_TASK);
    assign in_evt    = aligned && (addr[ADDR_W-1:8] == REGION_EVT);
    assign unused_hi = ^wdata;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            hit[i] = (word == WORD_W'(i));
        end
    end

    always_comb begin
        sw_trig  = '0;
        sw_clr   = '0;
        en_set   = '0;
        en_clr   = '0;
        rd_value = '0;
        if (in_task && wr && wdata[0]) begin
            sw_trig = hit;
        end
        if (in_evt) begin
            rd_value[0] = |(flags & hit);
            if (wr && !wdata[0]) begin
                sw_clr = hit;
            end
        end
        if (addr == OFS_MASK_RD || addr == OFS_MASK_SET || addr == OFS_MASK_CLR) begin
            rd_value[NUM_CH-1:0] = mask;
        end
        if (wr && addr == OFS_MASK_SET) begin
            en_set = wdata[NUM_CH-1:0];
        end
        if (wr && addr == OFS_MASK_CLR) begin
            en_clr = wdata[NUM_CH-1:0];
        end
    end

endmodule

// File: rtl/trig_evt_chan.sv
module trig_evt_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_trig,
    input  logic hw_trig,
    input  logic sw_clr,
    output logic flag,
    output logic pulse
);

    typedef struct packed {
        logic flag;
        logic pulse;
    } chan_state_t;

    chan_state_t s_d, s_q;
    logic        fire;

    assign fire = sw_trig | hw_trig;

    always_comb begin
        s_d       = s_q;
        s_d.flag  = fire | (s_q.flag & ~sw_clr);
        s_d.pulse = fire & ~s_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag  = s_q.flag;
    assign pulse = s_q.pulse;

    a_r1_task_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        sw_trig |=> flag);
    a_r2_hw_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hw_trig |=> flag);
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !sw_clr) |=> flag);
    a_r8_trigger_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_trig || hw_trig) && sw_clr) |=> flag);
    a_r9_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> pulse);
    a_r9_pulse_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $rose(flag));

endmodule

// File: rtl/trig_evt_inten.sv
module trig_evt_inten #(
    parameter int unsigned NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_bits,
    input  logic [NUM_CH-1:0] clr_bits,
    output logic [NUM_CH-1:0] mask
);

    typedef struct packed {
        logic [NUM_CH-1:0] mask;
    } en_state_t;

    en_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.mask = (s_q.mask | set_bits) & ~clr_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mask = s_q.mask;

    a_r4_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_bits && clr_bits == '0) |=> ((mask & $past(set_bits)) == $past(set_bits)));
    a_r5_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_bits) |=> ((mask & $past(clr_bits)) == '0));
    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits == '0 && clr_bits == '0) |=> $stable(mask));

endmodule

// File: rtl/trig_evt_unit.sv
module trig_evt_unit
    import trig_evt_pkg::*;
#(
    parameter int unsigned NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] hw_task,
    output logic [NUM_CH-1:0] evt_pulse,
    output logic              irq
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t        s_d, s_q;
    logic [NUM_CH-1:0] flags;
    logic [NUM_CH-1:0] mask;
    logic [NUM_CH-1:0] sw_trig;
    logic [NUM_CH-1:0] sw_clr;
    logic [NUM_CH-1:0] en_set;
    logic [NUM_CH-1:0] en_clr;
    logic [DATA_W-1:0] rd_value;

    trig_evt_decode #(.NUM_CH(NUM_CH)) u_decode (
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .flags    (flags),
        .mask     (mask),
        .sw_trig  (sw_trig),
        .sw_clr   (sw_clr),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .rd_value (rd_value)
    );

    trig_evt_inten #(.NUM_CH(NUM_CH)) u_inten (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (en_set),
        .clr_bits (en_clr),
        .mask     (mask)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        trig_evt_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .sw_trig (sw_trig[g]),
            .hw_trig (hw_task[g]),
            .sw_clr  (sw_clr[g]),
            .flag    (flags[g]),
            .pulse   (evt_pulse[g])
        );
    end

    always_comb begin
        s_d = s_q;
        if (bus_rd) begin
            s_d.rdata = rd_value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign irq       = |(flags & mask);

    a_r7_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
    a_r7_no_irq_without_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> !irq);
    a_r6_enable_makes_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_set && hw_task == '0) |=> (evt_pulse == '0));
    a_r10_task_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[11:8] == REGION_TASK) |=> (bus_rdata == '0));
    a_r12_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/tb_trig_evt_unit.sv
module tb_trig_evt_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 16;

    localparam int K_RDATA = 0;
    localparam int K_IRQ   = 1;
    localparam int K_PULSE = 2;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  hw_task = '0;
    logic [NCH-1:0]  evt_pulse;
    logic            irq;

    item_t           sb_q[$];
    int              n_checks = 0;
    int              n_fail = 0;
    bit              finished = 1'b0;

    logic [NCH-1:0]  m_flag = '0;
    logic [NCH-1:0]  m_mask = '0;
    logic [31:0]     m_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_evt_unit #(.NUM_CH(NCH)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hw_task   (hw_task),
        .evt_pulse (evt_pulse),
        .irq       (irq)
    );

    function automatic logic [11:0] a_task(int n);
        return 12'(4 * n);
    endfunction

    function automatic logic [11:0] a_evt(int n);
        return 12'h100 + 12'(4 * n);
    endfunction

    function automatic bit chan_ok(logic [11:0] a);
        return (a[1:0] == 2'b00) && (a[7:2] < 6'(NCH));
    endfunction

    function automatic logic [31:0] model_read(logic [11:0] a);
        logic [31:0] v;
        v = '0;
        if (a[11:8] == 4'h1 && chan_ok(a)) v[0] = m_flag[a[5:2]];
        if (a == 12'h300 || a == 12'h304 || a == 12'h308) v[NCH-1:0] = m_mask;
        return v;
    endfunction

    task automatic push(int kind, logic [31:0] exp, string req);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb_q.push_back(it);
    endtask

    task automatic step(bit wr, bit rd, logic [11:0] a, logic [31:0] wd,
                        logic [NCH-1:0] hw, string req);
        logic [NCH-1:0] sets;
        logic [NCH-1:0] clrs;
        logic [NCH-1:0] nflag;
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; hw_task = hw;
        sets = hw;
        clrs = '0;
        if (wr && a[11:8] == 4'h0 && chan_ok(a) && wd[0]) sets[a[5:2]] = 1'b1;
        if (wr && a[11:8] == 4'h1 && chan_ok(a) && !wd[0]) clrs[a[5:2]] = 1'b1;
        if (rd) m_rdata = model_read(a);
        nflag = (m_flag & ~clrs) | sets;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0; hw_task = '0;
        push(K_PULSE, 32'(nflag & ~m_flag), req);
        m_flag = nflag;
        if (wr && a == 12'h304) m_mask = m_mask | wd[NCH-1:0];
        if (wr && a == 12'h308) m_mask = m_mask & ~wd[NCH-1:0];
        push(K_IRQ, {31'd0, |(m_flag & m_mask)}, req);
        push(K_RDATA, m_rdata, req);
    endtask

    task automatic wr_op(logic [11:0] a, logic [31:0] wd, string req);
        step(1'b1, 1'b0, a, wd, '0, req);
    endtask

    task automatic rd_op(logic [11:0] a, string req);
        step(1'b0, 1'b1, a, '0, '0, req);
    endtask

    task automatic hw_op(logic [NCH-1:0] hw, string req);
        step(1'b0, 1'b0, '0, '0, hw, req);
    endtask

    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_RDATA: act = bus_rdata;
                K_IRQ:   act = {31'd0, irq};
                default: act = 32'(evt_pulse);
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        push(K_PULSE, '0, "R11");
        push(K_IRQ, '0, "R11");
        push(K_RDATA, '0, "R11");
        rd_op(12'h300, "R11");
        rd_op(a_evt(3), "R11");
        // R1 and R6: software task with enable off
        wr_op(a_task(3), 32'h1, "R1");
        rd_op(a_evt(3), "R1");
        // R10: task reads zero, writing zero does nothing
        rd_op(a_task(3), "R10");
        wr_op(a_task(5), 32'h0, "R10");
        rd_op(a_evt(5), "R10");
        // R6: enabling does not create an event
        wr_op(12'h304, 32'h0000_0008, "R6");
        rd_op(a_evt(3), "R6");
        wr_op(12'h304, 32'h0000_0400, "R6");
        rd_op(a_evt(10), "R6");
        // R2: hardware pulse, disabled channel
        hw_op(16'h0080, "R2");
        rd_op(a_evt(7), "R2");
        // R3: write one to event register is ignored, zero clears
        wr_op(a_evt(3), 32'h1, "R3");
        rd_op(a_evt(3), "R3");
        wr_op(a_evt(3), 32'h0, "R3");
        rd_op(a_evt(3), "R7");
        // R4: enable set
        wr_op(12'h304, 32'h0, "R4");
        rd_op(12'h304, "R4");
        wr_op(12'h304, 32'h0000_0080, "R4");
        rd_op(12'h300, "R4");
        wr_op(12'h300, 32'h0000_FFFF, "R5");
        rd_op(12'h300, "R5");
        // R5: enable clear
        wr_op(12'h308, 32'h0, "R5");
        wr_op(12'h308, 32'h0000_0080, "R5");
        rd_op(12'h308, "R5");
        // R8: collision of task and clear
        step(1'b1, 1'b0, a_evt(3), 32'h0, 16'h0008, "R8");
        step(1'b1, 1'b0, a_evt(3), 32'h0, 16'h0008, "R8");
        rd_op(a_evt(3), "R8");
        // R9: trigger on set flag, multi-channel pulses, same-cycle sw+hw
        wr_op(a_task(3), 32'h1, "R9");
        hw_op(16'h8001, "R9");
        step(1'b1, 1'b0, a_task(9), 32'h1, 16'h0200, "R9");
        // R7: irq through several channels and clears
        wr_op(12'h304, 32'h0000_8001, "R7");
        wr_op(a_evt(0), 32'h0, "R7");
        wr_op(a_evt(15), 32'h0, "R7");
        wr_op(a_evt(3), 32'h0, "R7");
        // R12: read timing, hold, unmapped
        rd_op(12'h200, "R12");
        hw_op(16'h0001, "R12");
        rd_op(a_evt(0), "R12");
        hw_op('0, "R12");
        rd_op(12'h3FC, "R12");
        for (int i = 0; i < NCH; i++) wr_op(a_evt(i), 32'h0, "R3");
        rd_op(12'h300, "R7");
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule